// File: doc/BRIEF.md
# Processor Init Pulse Generator

This block produces the active-low initialisation wire that tells the processor cores to restart integer execution. The wire idles high. When one of two control-register events occurs, the block pulls it low for a fixed number of PCI clock periods and then drives it high again. What the cores do in response is outside this block.

Two events start a pulse. The first is a rising edge on the "init request" control bit. The second is a rising edge on the "core reset" control bit, and it counts only while the "full system reset" select bit is clear. When that select bit is set, a core-reset edge is meant for the wider system reset path and is ignored here. The pulse length is measured in PCI clock periods. A clock-enable input marks the fabric-clock cycles that match a PCI clock edge, and the length counter advances only on those cycles.

Top module: `init_pulse_gen`

## Requirements
- R1: After synchronous reset, `init_n` is 1, and holding any control bit high through reset produces no pulse once reset is released.
- R2: A 0-to-1 change of `init_req` makes `init_n` go to 0 on the next clock edge.
- R3: A 0-to-1 change of `core_rst` while `sys_rst_sel` is 0 makes `init_n` go to 0 on the next clock edge.
- R4: A 0-to-1 change of `core_rst` while `sys_rst_sel` is 1 has no effect, and `init_n` stays 1.
- R5: Once a pulse starts, `init_n` stays 0 for exactly `PULSE_LEN` (default 16) clock edges on which `pci_ce` is 1, and then returns to 1.
- R6: The length counter does not advance on edges where `pci_ce` is 0.
- R7: A trigger that arrives while a pulse is in progress reloads the full count, so the low time runs `PULSE_LEN` enabled edges from the new trigger.
- R8: Holding a control bit at 1 does not start another pulse. Only a new 0-to-1 change does.
- R9: Asserting reset during a pulse ends the pulse and returns `init_n` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| pci_ce | input | 1 | Marks cycles that count as one PCI clock period |
| init_req | input | 1 | Init request control bit; a rising edge triggers a pulse |
| core_rst | input | 1 | Core reset control bit; a rising edge triggers a pulse unless selected for system reset |
| sys_rst_sel | input | 1 | Full system reset select; when 1, `core_rst` edges are ignored |
| init_n | output | 1 | Active-low processor init wire, registered |

## Verification
The bench builds the block with the default `PULSE_LEN` of 16, so the exact pulse length of sixteen PCI periods is checked directly. It runs that length under a free-running enable and under sparse enable patterns (every second and every third cycle), which exposes any counting on cycles that are not enabled. With the default length, a retrigger part-way through a pulse gives a distinct total low time (10 plus 16 cycles), so an ignored or partial reload would show up as a wrong count.

// File: rtl/init_pulse_pkg.sv
package init_pulse_pkg;
  // Number of bits needed to hold a count from 0 to max_val inclusive
  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

  // Trigger source bit positions inside the edge detector vector
  localparam int SRC_INIT = 0;
  localparam int SRC_CORE = 1;
  localparam int NUM_SRC  = 2;
endpackage

// File: rtl/init_edge_det.sv
module init_edge_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      // Tracks the level even in reset, so a bit held high through reset
      // gives no edge when reset is released
      always_ff @(posedge clk) begin
        prev[i] <= level[i];
      end
      assign rise[i] = level[i] & ~prev[i] & ~rst;

      // R8
      hold_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $past(level[i]) |-> !rise[i]);
    end
  endgenerate
endmodule

// File: rtl/init_pulse_timer.sv
module init_pulse_timer #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic pulse_n
);
  import init_pulse_pkg::*;
  localparam int CNT_W = cnt_width(PULSE_LEN);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pulse_n <= 1'b1;
    end else if (load) begin
      cnt     <= LOAD_VAL;
      pulse_n <= 1'b0;
    end else if (tick && cnt != '0) begin
      cnt     <= cnt - 1'b1;
      pulse_n <= (cnt == CNT_W'(1));
    end
  end

  // R7
  load_full_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == LOAD_VAL) && !pulse_n);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt) && $stable(pulse_n));
  // R5
  low_while_count_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) == !pulse_n);
  // R5
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD_VAL);
endmodule

// File: rtl/init_pulse_gen.sv
module init_pulse_gen #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pci_ce,
  input  logic init_req,
  input  logic core_rst,
  input  logic sys_rst_sel,
  output logic init_n
);
  import init_pulse_pkg::*;

  logic [NUM_SRC-1:0] src_level;
  logic [NUM_SRC-1:0] src_rise;
  logic               fire;

  assign src_level[SRC_INIT] = init_req;
  assign src_level[SRC_CORE] = core_rst;

  init_edge_det #(.WIDTH(NUM_SRC)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (src_level),
    .rise  (src_rise)
  );

  assign fire = src_rise[SRC_INIT] | (src_rise[SRC_CORE] & ~sys_rst_sel);

  init_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (fire),
    .tick    (pci_ce),
    .pulse_n (init_n)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) $fell(rst) |-> init_n);
  // R2
  init_req_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (init_req && !$past(init_req)) |=> !init_n);
  // R3
  core_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (core_rst && !$past(core_rst) && !sys_rst_sel) |=> !init_n);
  // R4
  sel_block_chk: assert property (@(posedge clk) disable iff (rst)
    (init_n && !(init_req && !$past(init_req)) && sys_rst_sel) |=> init_n);
endmodule

// File: tb/init_pulse_gen_tb_top.sv
module init_pulse_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pci_ce = 1'b1;
  logic init_req = 1'b0;
  logic core_rst = 1'b0;
  logic sys_rst_sel = 1'b0;
  logic init_n;
  int checks = 0;
  int errors = 0;
  int ce_period = 1;
  int ce_phase = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  init_pulse_gen #(.PULSE_LEN(16)) dut_i (
    .clk(clk), .rst(rst), .pci_ce(pci_ce), .init_req(init_req),
    .core_rst(core_rst), .sys_rst_sel(sys_rst_sel), .init_n(init_n)
  );

  // Enable pattern: high one cycle in every ce_period, changed just after posedge
  always @(posedge clk) begin
    #2;
    ce_phase = (ce_phase + 1) % ce_period;
    pci_ce = (ce_phase == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges with init_n low and enabled cycles among them
  task automatic measure(output int lows, output int ces);
    lows = 0; ces = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (init_n) break;
      lows++;
      if (pci_ce) ces++;
    end
  endtask

  task automatic stay_high(input string req, input int n);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!init_n) lows++;
    end
    check(req, lows, 0);
  endtask

  task automatic clear_bits();
    @(negedge clk);
    init_req = 0; core_rst = 0; sys_rst_sel = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1; init_req = 1; core_rst = 1; sys_rst_sel = 0;
    repeat (3) @(negedge clk);
    check("R1 idle in reset", init_n, 1);
    rst = 0;
    stay_high("R1 no pulse from reset", 20);
    clear_bits();
  endtask

  task automatic t_init_req(input int period);
    int lows, ces;
    ce_period = period;
    @(negedge clk);
    init_req = 1;
    @(negedge clk);
    check("R2 low after init_req edge", init_n, 0);
    measure(lows, ces);
    check("R5 enabled edges while low", ces + (pci_ce ? 0 : 0) + 1, 16);
    if (period == 1) check("R5 low cycles", lows + 1, 16);
    else check("R6 low lasts longer than 16 cycles", int'(lows + 1 > 16), 1);
    clear_bits();
    ce_period = 1;
  endtask

  task automatic t_core(input bit sel);
    int lows, ces;
    @(negedge clk);
    sys_rst_sel = sel; core_rst = 1;
    if (sel) begin
      stay_high("R4 core_rst ignored when selected", 20);
    end else begin
      @(negedge clk);
      check("R3 low after core_rst edge", init_n, 0);
      measure(lows, ces);
      check("R3 pulse length", lows + 1, 16);
    end
    clear_bits();
  endtask

  task automatic t_restart();
    int lows, ces;
    @(negedge clk);
    init_req = 1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (i == 5) init_req = 0;
      if (i == 10) init_req = 1;
    end
    measure(lows, ces);
    check("R7 restarted low time", lows + 10, 26);
    clear_bits();
  endtask

  task automatic t_hold();
    int lows, ces;
    @(negedge clk);
    init_req = 1;
    @(negedge clk);
    measure(lows, ces);
    check("R8 first pulse", lows + 1, 16);
    stay_high("R8 held bit no retrigger", 20);
    clear_bits();
  endtask

  task automatic t_abort();
    @(negedge clk);
    init_req = 1;
    repeat (5) @(negedge clk);
    check("R9 pulse running", init_n, 0);
    rst = 1;
    @(negedge clk);
    check("R9 reset ends pulse", init_n, 1);
    rst = 0;
    stay_high("R9 stays high", 20);
    clear_bits();
  endtask

  initial begin
    t_reset();
    t_init_req(1);
    t_init_req(2);
    t_init_req(3);
    t_core(1'b0);
    t_core(1'b1);
    t_restart();
    t_hold();
    t_abort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule